// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The block folds a wide set of level-sensitive peripheral interrupt lines into a smaller set of summary requests for an upstream interrupt controller. Lines are handled in groups of eight; each group owns one output that is raised while any of its lines is both asserted and enabled. Input line `k` belongs to group `k/8` at bit `k%8`.

Four groups share one 32-bit register bank. Group `n` lives in bank `n/4` at bits `[(n%4)*8 +: 8]`, and banks sit 0x10 bytes apart in the address space. Software never writes the enable state directly. It sets enable bits through one word and clears them through another, so separate drivers can own different groups of the same bank without a read-modify-write. A masked status word shows which enabled lines are active right now. The usual start-up step writes a group's 8-bit mask to the clear word, which leaves that group fully disabled.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset every enable bit is 0, every group output is 0, and every status word reads 0 whatever the inputs are.
- R2: A write at bank offset 0x0 sets each enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R3: A write at bank offset 0x4 clears each enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R4: A read at bank offset 0x0 returns the bank's 32 current enable bits.
- R5: A read at bank offset 0xC returns the bank's 32 raw input levels ANDed with their enable bits. Bank `b` bit `i` is input line `b*32+i`, and that read reflects the inputs in the same cycle.
- R6: Output `n` is the OR of the 8 masked status bits of group `n`, registered. It changes at the first clock edge after the inputs or enables that cause the change.
- R7: Reads at offsets 0x4 and 0x8 return 0. Writes at offsets 0x8 and 0xC change no enable bit.
- R8: An access whose bank index is at or beyond NUM_GROUPS/4, or whose address bits [1:0] are not 0, reads 0 and changes no enable bit.
- R9: Inputs are level-sensitive. An output stays high for as long as an enabled line stays high, and it falls one edge after the line drops or its enable is cleared.
- R10: Clearing the 8-bit mask of one group leaves the enables and outputs of the other groups in the same bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address: bits [ADDR_W-1:4] select the bank, bits [3:2] select the word |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, sampled at the clock edge |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_i | input | NUM_GROUPS*8 | Raw level-sensitive interrupt lines |
| grp_irq_o | output | NUM_GROUPS | One registered summary request per group |

## Verification
The bench writes set and clear words whose data holds zeros beside ones. A design that wrote the enable register directly, instead of setting or clearing bits, would wipe bits that should be kept. It checks the one-edge delay on the outputs by sampling both before and after the edge. A design with no output register, or with one register too many, would show the new value one cycle early or one cycle late. It also aims at the reserved word, writes to the status word, misaligned addresses and the first bank past the end, where decode that is too loose would alias into a real bank. Finally, it clears one group inside a shared bank, which catches a design that clears the whole 32-bit word.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int unsigned REG_W         = 32;
  localparam int unsigned GRP_W         = 8;
  localparam int unsigned GRPS_PER_BANK = REG_W / GRP_W;
  localparam int unsigned BANK_LSB      = 4;   // 0x10 bank stride

  typedef enum logic [1:0] {
    SLOT_SET  = 2'd0,
    SLOT_CLR  = 2'd1,
    SLOT_RSV  = 2'd2,
    SLOT_STAT = 2'd3
  } slot_e;
endpackage

// File: rtl/irqc_bank.sv
`timescale 1ns/1ps
module irqc_bank
  import irqc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] irq_i,
  output logic [REG_W-1:0] en_o,
  output logic [REG_W-1:0] stat_o
);
  logic [REG_W-1:0] en_q, set_bits, clr_bits;

  assign set_bits = set_i ? wdata_i : '0;
  assign clr_bits = clr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= (en_q | set_bits) & ~clr_bits;
  end

  assign en_o   = en_q;
  assign stat_o = irq_i & en_q;
endmodule

// File: rtl/irqc_group_or.sv
`timescale 1ns/1ps
module irqc_group_or
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 16,
  localparam int unsigned NUM_LINES = NUM_GROUPS * GRP_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LINES-1:0]  stat_i,
  output logic [NUM_GROUPS-1:0] grp_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) grp_o[g] <= 1'b0;
      else         grp_o[g] <= |stat_i[g*GRP_W +: GRP_W];
    end
  end
endmodule

// File: rtl/irqc_rd_mux.sv
`timescale 1ns/1ps
module irqc_rd_mux
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BIDX_W    = 4,
  localparam int unsigned FLAT_W   = NUM_BANKS * REG_W
) (
  input  logic              hit_i,
  input  logic [BIDX_W-1:0] bank_i,
  input  slot_e             slot_i,
  input  logic [FLAT_W-1:0] en_i,
  input  logic [FLAT_W-1:0] stat_i,
  output logic [REG_W-1:0]  rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (hit_i) begin
      for (int b = 0; b < int'(NUM_BANKS); b++) begin
        if (bank_i == BIDX_W'(b)) begin
          unique case (slot_i)
            SLOT_SET:  rdata_o = en_i[b*REG_W +: REG_W];
            SLOT_STAT: rdata_o = stat_i[b*REG_W +: REG_W];
            default:   rdata_o = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/irq_group_combiner.sv
`timescale 1ns/1ps
module irq_group_combiner
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 16,  // multiple of 4
  parameter int unsigned ADDR_W     = 8,
  localparam int unsigned NUM_BANKS = NUM_GROUPS / GRPS_PER_BANK,
  localparam int unsigned NUM_LINES = NUM_GROUPS * GRP_W,
  localparam int unsigned BIDX_W    = ADDR_W - BANK_LSB
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [REG_W-1:0]      wdata_i,
  input  logic                  we_i,
  output logic [REG_W-1:0]      rdata_o,
  input  logic [NUM_LINES-1:0]  irq_i,
  output logic [NUM_GROUPS-1:0] grp_irq_o
);
  logic [BIDX_W-1:0]    bank_idx;
  slot_e                slot;
  logic                 hit;
  logic [NUM_BANKS-1:0] set_sel, clr_sel;
  logic [NUM_LINES-1:0] en_flat, stat_flat;

  assign bank_idx = addr_i[ADDR_W-1:BANK_LSB];
  assign slot     = slot_e'(addr_i[BANK_LSB-1:2]);
  // aligned word inside an existing bank
  assign hit = (addr_i[1:0] == 2'b00) &&
               ({1'b0, bank_idx} < (BIDX_W+1)'(NUM_BANKS));

  always_comb begin
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      set_sel[b] = we_i && hit && (bank_idx == BIDX_W'(b)) && (slot == SLOT_SET);
      clr_sel[b] = we_i && hit && (bank_idx == BIDX_W'(b)) && (slot == SLOT_CLR);
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irqc_bank u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_sel[b]),
      .clr_i   (clr_sel[b]),
      .wdata_i (wdata_i),
      .irq_i   (irq_i[b*REG_W +: REG_W]),
      .en_o    (en_flat[b*REG_W +: REG_W]),
      .stat_o  (stat_flat[b*REG_W +: REG_W])
    );
  end

  irqc_group_or #(.NUM_GROUPS(NUM_GROUPS)) u_grp_or (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stat_i (stat_flat),
    .grp_o  (grp_irq_o)
  );

  irqc_rd_mux #(.NUM_BANKS(NUM_BANKS), .BIDX_W(BIDX_W)) u_rd_mux (
    .hit_i   (hit),
    .bank_i  (bank_idx),
    .slot_i  (slot),
    .en_i    (en_flat),
    .stat_i  (stat_flat),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/irqc_chk.sv
`timescale 1ns/1ps
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 16,
  parameter int unsigned ADDR_W     = 8,
  localparam int unsigned NUM_BANKS = NUM_GROUPS / GRPS_PER_BANK,
  localparam int unsigned NUM_LINES = NUM_GROUPS * GRP_W,
  localparam int unsigned BIDX_W    = ADDR_W - BANK_LSB
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [REG_W-1:0]      wdata_i,
  input logic                  we_i,
  input logic [REG_W-1:0]      rdata_o,
  input logic [NUM_LINES-1:0]  irq_i,
  input logic [NUM_GROUPS-1:0] grp_irq_o,
  input logic [NUM_LINES-1:0]  en_flat
);
  logic              in_bank, aligned, wr_set, wr_clr;
  logic              wr_set_q, wr_clr_q;
  logic [REG_W-1:0]  wdata_q;
  logic [BIDX_W-1:0] bank_q;

  assign aligned = addr_i[1:0] == 2'b00;
  assign in_bank = int'(addr_i[ADDR_W-1:BANK_LSB]) < int'(NUM_BANKS);
  assign wr_set  = we_i && aligned && in_bank && addr_i[3:2] == 2'd0;
  assign wr_clr  = we_i && aligned && in_bank && addr_i[3:2] == 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_set_q <= 1'b0; wr_clr_q <= 1'b0; wdata_q <= '0; bank_q <= '0;
    end else begin
      wr_set_q <= wr_set; wr_clr_q <= wr_clr; wdata_q <= wdata_i;
      bank_q   <= addr_i[ADDR_W-1:BANK_LSB];
    end
  end

  AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set_q |-> ((en_flat[int'(bank_q)*REG_W +: REG_W] & wdata_q) == wdata_q)); // R2
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr_q |-> ((en_flat[int'(bank_q)*REG_W +: REG_W] & wdata_q) == '0)); // R3
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_set || wr_clr) |=> $stable(en_flat)); // R7
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[3:2] == 2'd1 || addr_i[3:2] == 2'd2) |-> rdata_o == '0); // R7
  AST_OOR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_bank || !aligned) |-> rdata_o == '0); // R8

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_lat
    AST_GRP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grp_irq_o[g] == $past(|(irq_i[g*GRP_W +: GRP_W] & en_flat[g*GRP_W +: GRP_W]))); // R6
  end
endmodule

bind irq_group_combiner irqc_chk #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .we_i      (we_i),
  .rdata_o   (rdata_o),
  .irq_i     (irq_i),
  .grp_irq_o (grp_irq_o),
  .en_flat   (en_flat)
);

// File: tb/irq_group_combiner_tb_top.sv
`timescale 1ns/1ps
module irq_group_combiner_tb_top;
  localparam int NG = 16;
  localparam int AW = 8;
  localparam int NL = NG * 8;
  localparam int NB = NG / 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          we = 1'b0;
  logic [31:0]   rdata;
  logic [NL-1:0] irq = '0;
  logic [NG-1:0] grp;

  always #10 clk = ~clk;  // 50 MHz

  irq_group_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .irq_i(irq), .grp_irq_o(grp)
  );

  typedef struct {
    logic [31:0] exp;
    bit          is_grp;
    string       tag;
  } item_t;

  item_t         sb_q[$];
  int            n_chk = 0;
  int            n_err = 0;
  bit            done  = 1'b0;
  logic [NL-1:0] en_m  = '0;

  // monitor: compares results at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t       it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_grp ? 32'(grp) : rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [NG-1:0] model_grp();
    logic [NG-1:0] r;
    for (int g = 0; g < NG; g++) r[g] = |(irq[g*8 +: 8] & en_m[g*8 +: 8]);
    return r;
  endfunction

  function automatic logic [31:0] model_rd(logic [AW-1:0] a);
    int b;
    b = int'(a[AW-1:4]);
    if (a[1:0] != 2'b00 || b >= NB) return '0;
    case (a[3:2])
      2'd0:    return en_m[b*32 +: 32];
      2'd3:    return irq[b*32 +: 32] & en_m[b*32 +: 32];
      default: return '0;
    endcase
  endfunction

  task automatic push(logic [31:0] e, bit g, string tag);
    item_t it;
    it.exp = e; it.is_grp = g; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    int b;
    @(posedge clk); #1;
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0; wdata = '0;
    b = int'(a[AW-1:4]);
    if (a[1:0] == 2'b00 && b < NB) begin
      if (a[3:2] == 2'd0) en_m[b*32 +: 32] = en_m[b*32 +: 32] | d;
      if (a[3:2] == 2'd1) en_m[b*32 +: 32] = en_m[b*32 +: 32] & ~d;
    end
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    @(posedge clk); #1;
    addr = a;
    push(model_rd(a), 1'b0, tag);
    @(negedge clk); #1;
  endtask

  task automatic chk_grp(string tag);
    @(posedge clk); #1;
    push(32'(model_grp()), 1'b1, tag);
    @(negedge clk); #1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [NG-1:0] old_grp;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    irq = '1;
    // R1: reset state
    for (int b = 0; b < NB; b++) rd(AW'(b * 16), "R1 enable after reset");
    rd(8'h0C, "R1 status after reset");
    rd(8'h3C, "R1 status bank3 after reset");
    chk_grp("R1 outputs after reset");
    push(32'h0, 1'b0, "R1 literal zero");  // sampled with addr 0x3C, en all zero
    @(negedge clk); #1;

    irq = {32'h1234_8001, 32'h00FF_0000, 32'hA5C3_0F81, 32'h8000_0102};
    // R2/R4: set with zeros beside ones
    wr(8'h00, 32'h0000_00FF);
    rd(8'h00, "R2 R4 set low byte");
    wr(8'h00, 32'h00F0_0000);
    rd(8'h00, "R2 set keeps earlier bits");
    wr(8'h00, 32'h0);
    rd(8'h00, "R2 zero write no change");
    // R3: clear
    wr(8'h04, 32'h0000_000F);
    rd(8'h00, "R3 clear nibble");
    wr(8'h04, 32'h0);
    rd(8'h00, "R3 zero clear no change");
    // R5: status mapping
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h10, 32'h0000_FFFF);
    rd(8'h3C, "R5 bank3 status");
    rd(8'h0C, "R5 bank0 status");
    rd(8'h1C, "R5 bank1 status");
    rd(8'h2C, "R5 bank2 none enabled");
    // R6: OR per group and one-edge latency
    chk_grp("R6 group outputs");
    old_grp = model_grp();
    @(posedge clk); #1;
    irq[97] = ~irq[97];
    irq[0]  = 1'b0;
    push(32'(old_grp), 1'b1, "R6 output before edge");
    @(negedge clk); #1;
    chk_grp("R6 output after edge");
    // R7: reserved words
    rd(8'h04, "R7 read clear word");
    rd(8'h08, "R7 read reserved word");
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h20, "R7 writes to 0x8/0xC ignored");
    rd(8'h00, "R7 bank0 unchanged");
    // R8: out of range and misaligned
    rd(8'h40, "R8 first bank past end");
    rd(8'hF0, "R8 top bank past end");
    rd(8'h01, "R8 misaligned read");
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h21, 32'hFFFF_FFFF);
    for (int b = 0; b < NB; b++) rd(AW'(b * 16), "R8 enables unchanged");
    chk_grp("R8 outputs unchanged");
    // R9: level behaviour
    irq[127:96] = 32'h0101_0101;
    repeat (4) chk_grp("R9 held level");
    irq[127:96] = 32'h0100_0000;
    chk_grp("R9 input dropped");
    wr(8'h34, 32'h0100_0000);
    chk_grp("R9 enable cleared");
    // R10: per-group clear inside a bank
    irq[127:96] = 32'hFFFF_FFFF;
    wr(8'h34, 32'h0000_FF00);
    rd(8'h30, "R10 other groups keep enables");
    chk_grp("R10 other groups keep outputs");

    @(posedge clk); #1;
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule